// File: doc/BRIEF.md
# Process-Tagged Associative Operand Store

This block is a small, fully associative operand store. It sits in an operand pipeline between address formation and operand assembly. Each line holds a tag and a 64-bit value word. The tag is a process number placed above a name address. A lookup presents the same pair of fields as its key. The search and the value read happen in two separate registered stages.

Stage one compares the key against every valid tag. It registers a hit flag and the binary index of the matching line. Stage two uses that registered index to read the value word and registers the word. A 64-bit word carries two 32-bit operands. A half-select bit travels with each lookup and picks which half is presented as the narrow operand.

A separate write port loads a line chosen by a round-robin pointer and marks it valid. An invalidate-all input empties the store. A single advance enable lets the surrounding pipeline stall both stages together.

Top module: `pns_store`

## Requirements
- R1: While `rst_n` is low at a rising edge, every line becomes invalid, the round-robin pointer returns to line 0, and `s1_hit`, `s1_line`, `s2_hit`, `s2_value` and `s2_operand` are all zero.
- R2: A lookup hits only when `lk_req` is 1 and a valid line's tag equals {`lk_pn`, `lk_addr`}, with the process number in the upper bits. A mismatch in either field is a miss.
- R3: At a rising edge with `adv_en`=1, `s1_hit` and `s1_line` take the result of the lookup presented in that cycle. On a miss, or when `lk_req`=0, `s1_hit`=0 and `s1_line`=0.
- R4: When several valid lines match the key, `s1_line` is the lowest-numbered matching line.
- R5: At a rising edge with `adv_en`=1, `s2_hit` takes `s1_hit` and `s2_value` takes the 64-bit word of line `s1_line`. When `s1_hit`=0, `s2_value` becomes 0.
- R6: `s2_operand` is bits 63:32 of `s2_value` when the lookup's `lk_upper` was 1, and bits 31:0 when it was 0. The select bit travels with its lookup through both stages.
- R7: With `wr_en`=1 and `inv_all`=0 at a rising edge, the line at the round-robin pointer takes tag {`wr_pn`, `wr_addr`} and value `wr_value` and becomes valid. The pointer then steps to the next line, wrapping from 31 to 0. Writes take effect whatever `adv_en` is.
- R8: With `inv_all`=1 at a rising edge, every line becomes invalid, the pointer returns to 0, and a write in the same cycle is dropped.
- R9: A lookup or value read in the same cycle as a write to the same line sees the line's contents from before the write.
- R10: At a rising edge with `adv_en`=0, `s1_hit`, `s1_line`, `s2_hit`, `s2_value` and `s2_operand` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| adv_en | input | 1 | Advance enable for both pipeline stages |
| lk_req | input | 1 | A lookup is presented this cycle |
| lk_pn | input | 4 | Lookup process number |
| lk_addr | input | 10 | Lookup name address |
| lk_upper | input | 1 | Operand half select for this lookup (1 = bits 63:32) |
| wr_en | input | 1 | Load the line at the round-robin pointer |
| wr_pn | input | 4 | Process number of the tag being written |
| wr_addr | input | 10 | Name address of the tag being written |
| wr_value | input | 64 | Value word being written |
| inv_all | input | 1 | Invalidate every line and reset the pointer |
| s1_hit | output | 1 | Stage-one hit flag |
| s1_line | output | 5 | Stage-one matching line index |
| s2_hit | output | 1 | Stage-two hit flag |
| s2_value | output | 64 | Stage-two value word |
| s2_operand | output | 32 | Selected 32-bit half of `s2_value` |

## Verification
The assertions assume that `adv_en`, `lk_req`, `wr_en` and `inv_all` are never unknown once reset is released. They also assume that reset is held low for at least one rising edge before any traffic starts. The bench drives every input on the falling edge from known values and holds reset over several edges. It deliberately reuses keys so that duplicate tags exist; priority is then exercised rather than assumed. Stalls, invalidation and writes that coincide with lookups of the same line all occur within this input discipline.

// File: rtl/pns_pkg.sv
// Package: shared defaults for the process-tagged operand store.
// Assumes: the entry count is a power of two no smaller than 2.
package pns_pkg;
    localparam int PNS_ENTRIES = 32;
    localparam int PNS_PN_W    = 4;
    localparam int PNS_ADDR_W  = 10;
    localparam int PNS_VAL_W   = 64;
endpackage

// File: rtl/pns_prio_enc.sv
// Module: lowest-index priority encoder.
// Converts a match vector into a flag and the binary index of the lowest
// set bit. Assumes NUM >= 2 and IDX_W = $clog2(NUM).
module pns_prio_enc #(
    parameter int NUM   = 32,
    parameter int IDX_W = $clog2(NUM)
) (
    input  logic [NUM-1:0]   req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so that the lowest set bit is assigned last.
    always_comb begin
        idx = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    // Any-match flag.
    assign any = |req;
endmodule

// File: rtl/pns_tag_array.sv
// Module: associative tag field with valid bits and round-robin fill.
// Compares the lookup key with every stored tag in parallel. It also owns
// the fill pointer and the valid bits. Invalidate-all wins over a write.
// Assumes ENTRIES is a power of two and LINE_W = $clog2(ENTRIES).
module pns_tag_array #(
    parameter int ENTRIES = 32,
    parameter int KEY_W   = 14,
    parameter int LINE_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_all,
    input  logic              wr_en,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic              lk_req,
    input  logic [KEY_W-1:0]  lk_key,
    output logic [ENTRIES-1:0] match_vec,
    output logic              wr_fire,
    output logic [LINE_W-1:0] wr_line
);
    logic [KEY_W-1:0]   tag_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [LINE_W-1:0]  ptr_q;

    // A write is performed only when no invalidate is requested.
    assign wr_fire = wr_en && !inv_all;
    assign wr_line = ptr_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_line
        // Parallel comparator for one line.
        assign match_vec[g] = lk_req && valid_q[g] && (tag_q[g] == lk_key);

        // Tag storage for one line, loaded when the pointer selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                tag_q[g] <= '0;
            else if (wr_fire && (ptr_q == LINE_W'(g)))
                tag_q[g] <= wr_key;
        end
    end

    // Valid bits: cleared by reset or invalidate-all, set by a write.
    always_ff @(posedge clk) begin
        if (!rst_n || inv_all)
            valid_q <= '0;
        else if (wr_en)
            valid_q[ptr_q] <= 1'b1;
    end

    // Round-robin fill pointer, wrapping naturally at a power of two.
    always_ff @(posedge clk) begin
        if (!rst_n || inv_all)
            ptr_q <= '0;
        else if (wr_en)
            ptr_q <= ptr_q + 1'b1;
    end

    // R8
    inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (valid_q == '0));

    // R7
    wr_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> valid_q[$past(ptr_q)]);
endmodule

// File: rtl/pns_value_array.sv
// Module: value field with a registered read port.
// The read address is the registered line index from the match stage.
// A read in the same cycle as a write to that line returns the old word.
// A miss loads zero. Assumes LINE_W = $clog2(ENTRIES).
module pns_value_array #(
    parameter int ENTRIES = 32,
    parameter int VAL_W   = 64,
    parameter int LINE_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [VAL_W-1:0]  wr_data,
    input  logic              rd_adv,
    input  logic              rd_hit,
    input  logic [LINE_W-1:0] rd_line,
    output logic [VAL_W-1:0]  rd_data_q
);
    logic [VAL_W-1:0] mem [ENTRIES];

    // Value storage write.
    always_ff @(posedge clk) begin
        if (wr_fire) mem[wr_line] <= wr_data;
    end

    // Registered read of the addressed word; a miss returns zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data_q <= '0;
        else if (rd_adv)
            rd_data_q <= rd_hit ? mem[rd_line] : '0;
    end
endmodule

// File: rtl/pns_store.sv
// Module: process-tagged associative operand store (top).
// Stage one registers the hit flag and line index of the key
// {process number, address}. Stage two registers the 64-bit word of that
// line and offers a selected 32-bit half. adv_en stalls both stages.
// Writes and invalidation are independent of adv_en.
module pns_store
    import pns_pkg::*;
#(
    parameter int ENTRIES = PNS_ENTRIES,
    parameter int PN_W    = PNS_PN_W,
    parameter int ADDR_W  = PNS_ADDR_W,
    parameter int VAL_W   = PNS_VAL_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       adv_en,
    input  logic                       lk_req,
    input  logic [PN_W-1:0]            lk_pn,
    input  logic [ADDR_W-1:0]          lk_addr,
    input  logic                       lk_upper,
    input  logic                       wr_en,
    input  logic [PN_W-1:0]            wr_pn,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [VAL_W-1:0]           wr_value,
    input  logic                       inv_all,
    output logic                       s1_hit,
    output logic [$clog2(ENTRIES)-1:0] s1_line,
    output logic                       s2_hit,
    output logic [VAL_W-1:0]           s2_value,
    output logic [VAL_W/2-1:0]         s2_operand
);
    localparam int KEY_W  = PN_W + ADDR_W;
    localparam int LINE_W = $clog2(ENTRIES);
    localparam int HALF_W = VAL_W / 2;

    logic [ENTRIES-1:0] match_vec;
    logic               wr_fire;
    logic [LINE_W-1:0]  wr_line;
    logic               enc_any;
    logic [LINE_W-1:0]  enc_idx;
    logic               s1_upper_q;
    logic               s2_upper_q;

    pns_tag_array #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .LINE_W(LINE_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .inv_all  (inv_all),
        .wr_en    (wr_en),
        .wr_key   ({wr_pn, wr_addr}),
        .lk_req   (lk_req),
        .lk_key   ({lk_pn, lk_addr}),
        .match_vec(match_vec),
        .wr_fire  (wr_fire),
        .wr_line  (wr_line)
    );

    pns_prio_enc #(.NUM(ENTRIES), .IDX_W(LINE_W)) u_enc (
        .req(match_vec),
        .any(enc_any),
        .idx(enc_idx)
    );

    // Stage one: register the match outcome and the half select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_hit     <= 1'b0;
            s1_line    <= '0;
            s1_upper_q <= 1'b0;
        end else if (adv_en) begin
            s1_hit     <= enc_any;
            s1_line    <= enc_idx;
            s1_upper_q <= lk_upper;
        end
    end

    pns_value_array #(.ENTRIES(ENTRIES), .VAL_W(VAL_W), .LINE_W(LINE_W)) u_vals (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_fire  (wr_fire),
        .wr_line  (wr_line),
        .wr_data  (wr_value),
        .rd_adv   (adv_en),
        .rd_hit   (s1_hit),
        .rd_line  (s1_line),
        .rd_data_q(s2_value)
    );

    // Stage two: carry the hit flag and half select beside the value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_hit     <= 1'b0;
            s2_upper_q <= 1'b0;
        end else if (adv_en) begin
            s2_hit     <= s1_hit;
            s2_upper_q <= s1_upper_q;
        end
    end

    // Operand assembly: choose one half of the value word.
    assign s2_operand = s2_upper_q ? s2_value[VAL_W-1:HALF_W] : s2_value[HALF_W-1:0];

    // R3
    idle_lookup_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && !lk_req) |=> !s1_hit);

    // R5
    hit_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_en |=> (s2_hit == $past(s1_hit)));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_en |=> ($stable(s1_hit) && $stable(s1_line) && $stable(s2_hit)
                     && $stable(s2_value) && $stable(s2_operand)));
endmodule

// File: tb/sim_pns_store.sv
module sim_pns_store;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv_en = 1'b0, lk_req = 1'b0, lk_upper = 1'b0;
    logic [3:0]  lk_pn = '0, wr_pn = '0;
    logic [9:0]  lk_addr = '0, wr_addr = '0;
    logic        wr_en = 1'b0, inv_all = 1'b0;
    logic [63:0] wr_value = '0;
    logic        s1_hit, s2_hit;
    logic [4:0]  s1_line;
    logic [63:0] s2_value;
    logic [31:0] s2_operand;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model built from the requirements.
    logic [13:0] m_tag [32];
    logic [63:0] m_val [32];
    logic [31:0] m_valid = '0;
    int          m_ptr = 0;
    logic        e1_hit = 0, e1_up = 0, e2_hit = 0, e2_up = 0;
    logic [4:0]  e1_line = '0;
    logic [63:0] e2_val = '0;

    pns_store u0 (
        .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .lk_req(lk_req),
        .lk_pn(lk_pn), .lk_addr(lk_addr), .lk_upper(lk_upper),
        .wr_en(wr_en), .wr_pn(wr_pn), .wr_addr(wr_addr), .wr_value(wr_value),
        .inv_all(inv_all), .s1_hit(s1_hit), .s1_line(s1_line),
        .s2_hit(s2_hit), .s2_value(s2_value), .s2_operand(s2_operand)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [3:0] kpn(int i);
        return 4'(i % 16);
    endfunction
    function automatic logic [9:0] kad(int i);
        return 10'(i * 29 + 3);
    endfunction
    function automatic logic [63:0] kval(int i, int salt);
        return {32'hA500_0000 + 32'(i) + 32'(salt << 8), 32'h5A00_0000 ^ 32'(i * 3 + salt)};
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock: drive on the falling edge, update model, compare after the edge.
    task automatic step(string tag, bit adv, bit req, logic [3:0] pn, logic [9:0] ad,
                        bit up, bit we, logic [3:0] wpn, logic [9:0] wad,
                        logic [63:0] wv, bit inv);
        logic        n_hit;
        logic [4:0]  n_line;
        @(negedge clk);
        adv_en = adv; lk_req = req; lk_pn = pn; lk_addr = ad; lk_upper = up;
        wr_en = we; wr_pn = wpn; wr_addr = wad; wr_value = wv; inv_all = inv;
        @(posedge clk);
        n_hit = 1'b0; n_line = '0;
        for (int i = 31; i >= 0; i--)
            if (req && m_valid[i] && m_tag[i] == {pn, ad}) begin
                n_hit = 1'b1; n_line = 5'(i);
            end
        if (adv) begin
            e2_hit = e1_hit; e2_up = e1_up;
            e2_val = e1_hit ? m_val[e1_line] : 64'h0;
            e1_hit = n_hit; e1_line = n_line; e1_up = up;
        end
        if (inv) begin
            m_valid = '0; m_ptr = 0;
        end else if (we) begin
            m_tag[m_ptr] = {wpn, wad}; m_val[m_ptr] = wv;
            m_valid[m_ptr] = 1'b1; m_ptr = (m_ptr + 1) % 32;
        end
        #(CLK_P/4);
        chk(tag, "s1_hit", 64'(s1_hit), 64'(e1_hit));
        chk(tag, "s1_line", 64'(s1_line), 64'(e1_line));
        chk(tag, "s2_hit", 64'(s2_hit), 64'(e2_hit));
        chk(tag, "s2_value", s2_value, e2_val);
        chk(tag, "s2_operand", 64'(s2_operand), 64'(e2_up ? e2_val[63:32] : e2_val[31:0]));
    endtask

    task automatic look(string tag, int i, bit up);
        step(tag, 1, 1, kpn(i), kad(i), up, 0, '0, '0, '0, 0);
    endtask
    task automatic idle(string tag, int n);
        for (int k = 0; k < n; k++) step(tag, 1, 0, '0, '0, 0, 0, '0, '0, '0, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin m_tag[i] = '0; m_val[i] = '0; end
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        // R1: reset state at the outputs
        chk("R1", "s1_hit", 64'(s1_hit), 0);
        chk("R1", "s1_line", 64'(s1_line), 0);
        chk("R1", "s2_hit", 64'(s2_hit), 0);
        chk("R1", "s2_value", s2_value, 0);
        chk("R1", "s2_operand", 64'(s2_operand), 0);
        @(negedge clk) rst_n = 1'b1;

        // R1: empty store misses everything
        for (int i = 0; i < 4; i++) look("R1", i, 0);
        // R7/R9: fill all lines; each write looks up its own key (old = invalid)
        for (int i = 0; i < 32; i++)
            step("R7", 1, 1, kpn(i), kad(i), 0, 1, kpn(i), kad(i), kval(i, 0), 0);
        idle("R7", 2);
        // R2/R6: every stored key, both halves
        for (int i = 0; i < 32; i++) look("R6", i, i[0]);
        for (int i = 0; i < 32; i++) look("R2", 31 - i, ~i[0]);
        // R2: process number differs, address matches -> miss
        for (int i = 0; i < 32; i++)
            step("R2", 1, 1, kpn(i) + 4'd1, kad(i), 0, 0, '0, '0, '0, 0);
        // R3: request low with a stored key -> no hit
        for (int i = 0; i < 4; i++)
            step("R3", 1, 0, kpn(i), kad(i), 1, 0, '0, '0, '0, 0);
        // R4: duplicate key of line 20 written into lines 0 and 1
        step("R4", 1, 0, '0, '0, 0, 1, kpn(20), kad(20), kval(20, 1), 0);
        look("R4", 20, 1);
        step("R4", 1, 0, '0, '0, 0, 1, kpn(20), kad(20), kval(20, 2), 0);
        look("R4", 20, 0);
        idle("R4", 2);
        // R9: lookup of line 2 while line 2 is rewritten; then value-read race on line 3
        step("R9", 1, 1, kpn(2), kad(2), 1, 1, 4'hF, 10'h3FF, kval(2, 5), 0);
        look("R9", 3, 0);
        step("R9", 1, 0, '0, '0, 0, 1, 4'hE, 10'h3FE, kval(3, 6), 0);
        idle("R9", 2);
        step("R9", 1, 1, 4'hF, 10'h3FF, 1, 0, '0, '0, '0, 0);
        idle("R9", 2);
        // R10: stall with changing inputs and a write underneath
        look("R10", 10, 1);
        look("R10", 11, 0);
        for (int k = 0; k < 3; k++)
            step("R10", 0, 1, kpn(12 + k), kad(12 + k), k[0], 1, 4'h7, 10'(500 + k), kval(40 + k, 0), 0);
        idle("R10", 3);
        // R8: invalidate with a concurrent write, then everything misses
        look("R8", 15, 1);
        step("R8", 1, 1, kpn(16), kad(16), 0, 1, 4'h9, 10'h111, kval(9, 9), 1);
        for (int i = 0; i < 32; i++) look("R8", i, 0);
        step("R8", 1, 1, 4'h9, 10'h111, 0, 0, '0, '0, '0, 0);
        step("R8", 1, 0, '0, '0, 0, 1, 4'h9, 10'h111, kval(9, 10), 0);
        step("R8", 1, 1, 4'h9, 10'h111, 1, 0, '0, '0, '0, 0);
        idle("R8", 2);
        // R1: reset again mid-traffic
        look("R1", 0, 0);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #(CLK_P/4);
        chk("R1", "s1_hit", 64'(s1_hit), 0);
        chk("R1", "s2_value", s2_value, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule